// File: doc/BRIEF.md
# ATM OAM Cell Generator

This block turns one OAM segmentation descriptor into one ATM cell. When a descriptor is accepted, the block captures the connection's default 4-octet header. It can then overwrite the VCI field, the PTI field, or both, with values carried in the descriptor. This is how F4 cells (VCI 3 or 4) and F5 cells (PTI 3'b100 or 3'b101) are produced. The header goes out first, followed by exactly 48 payload octets read from one buffer. The output is a byte-serial stream with valid/ready flow control.

When the descriptor asks for it, the block replaces the last ten payload bits with a CRC-10. After the cell it emits a one-cycle status record. That record is routed either to a dedicated OAM status queue or to the connection's own status queue. It also carries a single-buffer marker and an error flag for descriptors that break the OAM coding rules. HEC generation, cell scheduling and the memory system are outside this block.

Top module: `oam_cell_gen`

## Requirements
- R1: A descriptor whose buffer-mode field `desc_aal_opt` equals 2'b01 produces exactly 52 output octets: 4 header octets, then 48 payload octets. `cell_sop` is high on the first header octet only. Exactly 48 buffer octets are consumed.
- R2: Header octets leave most significant first: bits 31:24, then 23:16, then 15:8, then 7:0 of the header word.
- R3: With `desc_hdr_mod` = 0, the header equals `vc_header` whatever the write flags hold.
- R4: With `desc_hdr_mod` = 1 and `desc_wr_vci` = 1, header bits 19:4 are replaced by `desc_vci`. All other bits are kept. VCI 3 and VCI 4 give F4 segment and end-to-end cells.
- R5: With `desc_hdr_mod` = 1 and `desc_wr_pti` = 1, header bits 3:1 are replaced by `desc_pti`. All other bits are kept. PTI 3'b100 and 3'b101 give F5 cells.
- R6: With `desc_crc10` = 1, payload octets 0 to 45 pass unchanged, and bits 7:2 of octet 46 pass unchanged. Octet 46 bits 1:0 carry CRC bits 9:8, and octet 47 carries CRC bits 7:0. The CRC is polynomial x^10+x^9+x^5+x^4+x+1 with the register starting at zero, fed the first 374 payload bits MSB first with feedback from bit 9, which equals the remainder of those 374 bits followed by ten zero bits.
- R7: With `desc_crc10` = 0, all 48 payload octets pass unchanged.
- R8: `stat_qid` equals the `oam_stat_id` input captured at descriptor accept when `desc_oam_stat` = 1. Otherwise it equals `vc_stat_id` captured at accept.
- R9: A descriptor with `desc_aal_opt` not equal to 2'b01 produces no cell octets and consumes no buffer octets. The cycle after accept it yields a status record with `stat_single` = 0 and `stat_error` = 1.
- R10: In single-buffer mode, `stat_single` = 1. `stat_error` = 1 exactly when `desc_aal_mode` is not 2'b01, or `desc_bom` = 1, or `desc_eom` = 1, or `desc_crc10` = 0. The cell is still sent.
- R11: While `cell_ready` is low, no buffer octet is consumed and a presented header octet is held. While `buf_valid` is low in the payload phase, `cell_valid` is low.
- R12: `stat_valid` is a single-cycle pulse in the cycle after the last payload octet is transferred. `desc_ready` is high only when no cell or status is pending.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| desc_valid | input | 1 | Descriptor offered |
| desc_ready | output | 1 | Descriptor accepted when high with desc_valid |
| desc_aal_opt | input | 2 | Buffer mode, 2'b01 = single buffer |
| desc_aal_mode | input | 2 | Adaptation mode, 2'b01 required for OAM |
| desc_hdr_mod | input | 1 | Header modify enable |
| desc_wr_pti | input | 1 | Overwrite PTI |
| desc_wr_vci | input | 1 | Overwrite VCI |
| desc_pti | input | 3 | PTI override value |
| desc_vci | input | 16 | VCI override value |
| desc_bom | input | 1 | Begin-of-message flag, must be 0 |
| desc_eom | input | 1 | End-of-message flag, must be 0 |
| desc_crc10 | input | 1 | Insert CRC-10 |
| desc_oam_stat | input | 1 | Route status to the OAM queue |
| vc_header | input | 32 | Connection default header |
| vc_stat_id | input | STAT_W | Connection status queue |
| oam_stat_id | input | STAT_W | Dedicated OAM status queue |
| buf_valid | input | 1 | Buffer octet available |
| buf_data | input | 8 | Buffer octet |
| buf_ready | output | 1 | Buffer octet consumed |
| cell_valid | output | 1 | Cell octet valid |
| cell_data | output | 8 | Cell octet |
| cell_sop | output | 1 | First octet of cell |
| cell_ready | input | 1 | Downstream accepts octet |
| stat_valid | output | 1 | Status record pulse |
| stat_qid | output | STAT_W | Target status queue |
| stat_single | output | 1 | Single-buffer descriptor |
| stat_error | output | 1 | Descriptor coding error |

## Verification
The bench targets the payload boundary where octet 46 is split between buffer bits and CRC bits. A design that is off by one there would corrupt octet 45 or leave stale data in octet 47. It applies header-modify with only one write flag set at a time, which catches a design that writes both fields or clips the PTI bit range. A design that treats the flags as live without the enable is caught by the case where the flags are set and the enable is off.

A non-single descriptor is issued while a buffer octet is already presented. This exposes a design that reads the buffer or starts a cell anyway. Backpressure on both sides checks that a stalled output never drops or duplicates an octet, and that the status pulse lands one cycle after the final transfer.

// File: rtl/oam_cell_gen.sv
module oam_cell_gen #(
  parameter int STAT_W  = 5,
  parameter int PAY_LEN = 48
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              desc_valid,
  output logic              desc_ready,
  input  logic [1:0]        desc_aal_opt,
  input  logic [1:0]        desc_aal_mode,
  input  logic              desc_hdr_mod,
  input  logic              desc_wr_pti,
  input  logic              desc_wr_vci,
  input  logic [2:0]        desc_pti,
  input  logic [15:0]       desc_vci,
  input  logic              desc_bom,
  input  logic              desc_eom,
  input  logic              desc_crc10,
  input  logic              desc_oam_stat,
  input  logic [31:0]       vc_header,
  input  logic [STAT_W-1:0] vc_stat_id,
  input  logic [STAT_W-1:0] oam_stat_id,
  input  logic              buf_valid,
  input  logic [7:0]        buf_data,
  output logic              buf_ready,
  output logic              cell_valid,
  output logic [7:0]        cell_data,
  output logic              cell_sop,
  input  logic              cell_ready,
  output logic              stat_valid,
  output logic [STAT_W-1:0] stat_qid,
  output logic              stat_single,
  output logic              stat_error
);
  localparam int IW = $clog2(PAY_LEN);
  localparam logic [IW-1:0] LAST_IDX  = IW'(PAY_LEN - 1);
  localparam logic [IW-1:0] SPLIT_IDX = IW'(PAY_LEN - 2);
  localparam logic [IW-1:0] HDR_LAST  = IW'(3);
  localparam logic [9:0]    POLY      = 10'h233;

  typedef enum logic [1:0] {S_IDLE, S_HDR, S_PAY, S_STAT} st_t;

  st_t               st;
  logic [IW-1:0]     idx;
  logic [31:0]       hdr_q;
  logic [9:0]        crc_q;
  logic              crc_on, single_q, err_q;
  logic [STAT_W-1:0] qid_q;

  function automatic logic [9:0] crc_step(input logic [9:0] c_in, input logic [7:0] d, input int n);
    logic [9:0] c;
    logic       fb;
    c = c_in;
    for (int i = 0; i < 8; i++) begin
      if (i < n) begin
        fb = c[9] ^ d[7-i];
        c  = {c[8:0], 1'b0};
        if (fb) c = c ^ POLY;
      end
    end
    return c;
  endfunction

  logic [31:0] hdr_w;
  always_comb begin
    hdr_w = vc_header;
    if (desc_hdr_mod && desc_wr_vci) hdr_w[19:4] = desc_vci;
    if (desc_hdr_mod && desc_wr_pti) hdr_w[3:1]  = desc_pti;
  end

  wire accept    = desc_valid && desc_ready;
  wire single_in = (desc_aal_opt == 2'b01);
  wire bad_code  = (desc_aal_mode != 2'b01) || desc_bom || desc_eom || !desc_crc10;

  wire at_split  = (idx == SPLIT_IDX);
  wire at_last   = (idx == LAST_IDX);
  wire [9:0] crc_d = crc_step(crc_q, buf_data, at_split ? 6 : 8);

  logic [7:0] hdr_byte, pay_byte;
  always_comb begin
    case (idx[1:0])
      2'd0:    hdr_byte = hdr_q[31:24];
      2'd1:    hdr_byte = hdr_q[23:16];
      2'd2:    hdr_byte = hdr_q[15:8];
      default: hdr_byte = hdr_q[7:0];
    endcase
    if (crc_on && at_split)     pay_byte = {buf_data[7:2], crc_d[9:8]};
    else if (crc_on && at_last) pay_byte = crc_q[7:0];
    else                        pay_byte = buf_data;
  end

  assign desc_ready  = (st == S_IDLE);
  assign cell_valid  = (st == S_HDR) || (st == S_PAY && buf_valid);
  assign cell_data   = (st == S_HDR) ? hdr_byte : pay_byte;
  assign cell_sop    = (st == S_HDR) && (idx == '0);
  assign buf_ready   = (st == S_PAY) && cell_ready;
  assign stat_valid  = (st == S_STAT);
  assign stat_qid    = qid_q;
  assign stat_single = single_q;
  assign stat_error  = err_q;

  wire fire = cell_valid && cell_ready;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st       <= S_IDLE;
      idx      <= '0;
      hdr_q    <= '0;
      crc_q    <= '0;
      crc_on   <= 1'b0;
      single_q <= 1'b0;
      err_q    <= 1'b0;
      qid_q    <= '0;
    end else begin
      case (st)
        S_IDLE: if (accept) begin
          hdr_q    <= hdr_w;
          crc_q    <= '0;
          idx      <= '0;
          crc_on   <= desc_crc10;
          single_q <= single_in;
          err_q    <= single_in ? bad_code : 1'b1;
          qid_q    <= desc_oam_stat ? oam_stat_id : vc_stat_id;
          st       <= single_in ? S_HDR : S_STAT;
        end
        S_HDR: if (fire) begin
          if (idx == HDR_LAST) begin
            idx <= '0;
            st  <= S_PAY;
          end else begin
            idx <= idx + 1'b1;
          end
        end
        S_PAY: if (fire) begin
          crc_q <= crc_d;
          if (at_last) st <= S_STAT;
          else         idx <= idx + 1'b1;
        end
        default: st <= S_IDLE;
      endcase
    end
  end
endmodule

module oam_cell_gen_chk #(parameter int STAT_W = 5) (
  input logic       clk,
  input logic       rst_n,
  input logic       desc_valid,
  input logic       desc_ready,
  input logic [1:0] desc_aal_opt,
  input logic       buf_ready,
  input logic       cell_valid,
  input logic [7:0] cell_data,
  input logic       cell_sop,
  input logic       cell_ready,
  input logic       stat_valid,
  input logic       stat_single,
  input logic       stat_error
);
  // R11
  buf_stall_chk: assert property (@(posedge clk) disable iff (!rst_n)
    buf_ready |-> cell_ready);
  // R1
  sop_valid_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cell_sop |-> cell_valid);
  // R11
  hdr_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cell_sop && !cell_ready) |=> (cell_sop && $stable(cell_data)));
  // R12
  stat_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    stat_valid |=> !stat_valid);
  // R12
  idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    desc_ready |-> (!cell_valid && !stat_valid));
  // R9
  nonsingle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (desc_valid && desc_ready && desc_aal_opt != 2'b01) |=> (stat_valid && stat_error && !stat_single));
endmodule

bind oam_cell_gen oam_cell_gen_chk #(.STAT_W(STAT_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .desc_valid(desc_valid), .desc_ready(desc_ready),
  .desc_aal_opt(desc_aal_opt), .buf_ready(buf_ready), .cell_valid(cell_valid),
  .cell_data(cell_data), .cell_sop(cell_sop), .cell_ready(cell_ready),
  .stat_valid(stat_valid), .stat_single(stat_single), .stat_error(stat_error)
);

// File: tb/oam_cell_gen_bench.sv
module oam_cell_gen_bench;
  localparam int STAT_W = 5;

  logic clk = 1'b0;
  always #2 clk = ~clk;

  logic rst_n = 1'b0;
  logic desc_valid = 1'b0, desc_ready;
  logic [1:0] desc_aal_opt = '0, desc_aal_mode = '0;
  logic desc_hdr_mod = 0, desc_wr_pti = 0, desc_wr_vci = 0;
  logic [2:0] desc_pti = '0;
  logic [15:0] desc_vci = '0;
  logic desc_bom = 0, desc_eom = 0, desc_crc10 = 0, desc_oam_stat = 0;
  logic [31:0] vc_header = '0;
  logic [STAT_W-1:0] vc_stat_id = 5'd3, oam_stat_id = 5'd17;
  logic buf_valid = 1'b0, buf_ready;
  logic [7:0] buf_data = '0;
  logic cell_valid, cell_sop, cell_ready = 1'b0;
  logic [7:0] cell_data;
  logic stat_valid, stat_single, stat_error;
  logic [STAT_W-1:0] stat_qid;

  oam_cell_gen #(.STAT_W(STAT_W)) u_oam_cell_gen (.*);

  int tests = 0, fails = 0, cyc = 0, last_fire = 0, octet = 0;
  int rdy_mode = 0, gap_mode = 0;
  bit done = 0;
  string tag = "R1";
  logic [8:0] exp_b[$];
  logic [STAT_W+1:0] exp_s[$];
  logic [7:0] buf_q[$];

  always @(posedge clk) cyc <= cyc + 1;

  task automatic check(input bit ok, input string what, input int act, input int exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: %s got %0h expected %0h", tag, what, act, exp);
    end
  endtask

  // stimulus for buffer side and downstream ready
  initial begin
    bit bfire;
    forever begin
      @(negedge clk);
      bfire = buf_valid && buf_ready;
      @(posedge clk); #1;
      if (bfire) void'(buf_q.pop_front());
      if (!(buf_valid && !bfire)) begin
        buf_valid = (buf_q.size() > 0) && (gap_mode == 0 || ($urandom % 4) != 0);
      end
      if (buf_q.size() > 0) buf_data = buf_q[0];
      cell_ready = (rdy_mode == 0) ? 1'b1 : (($urandom % 3) != 0);
    end
  end

  // monitor / scoreboard
  initial begin
    logic [8:0] e;
    logic [STAT_W+1:0] s;
    forever begin
      @(negedge clk);
      if (rst_n && !done) begin
        if (!cell_ready && buf_ready) check(0, "R11 buffer read under stall", 1, 0);
        if (cell_valid && cell_ready) begin
          if (exp_b.size() == 0) check(0, "unexpected octet (R9/R1)", cell_data, 0);
          else begin
            e = exp_b.pop_front();
            check({cell_sop, cell_data} == e, $sformatf("octet %0d (R1/R2/R6)", octet), {cell_sop, cell_data}, e);
            octet++;
            last_fire = cyc;
          end
        end
        if (stat_valid) begin
          if (exp_s.size() == 0) check(0, "unexpected status R12", 1, 0);
          else begin
            s = exp_s.pop_front();
            check({stat_qid, stat_single, stat_error} == s, "status R8/R10", {stat_qid, stat_single, stat_error}, s);
            if (s[1]) check(cyc == last_fire + 1, "R12 status timing", cyc - last_fire, 1);
          end
        end
      end
    end
  end

  function automatic logic [9:0] ref_crc(input logic [7:0] p[48]);
    logic [9:0] c = '0;
    logic fb;
    for (int k = 0; k < 374; k++) begin
      fb = c[9] ^ p[k/8][7 - (k%8)];
      c = {c[8:0], 1'b0} ^ (fb ? 10'b1000110011 : 10'b0);
    end
    return c;
  endfunction

  task automatic run_desc(input logic [1:0] opt, input logic [1:0] mode, input logic hm, input logic wp,
                          input logic wv, input logic [2:0] pti, input logic [15:0] vci,
                          input logic bom, input logic eom, input logic crc, input logic os,
                          input logic [31:0] hdr, input int seed, input string t);
    logic [7:0] p[48];
    logic [7:0] q[48];
    logic [31:0] h;
    logic [9:0] c;
    logic err;
    tag = t;
    octet = 0;
    for (int i = 0; i < 48; i++) begin p[i] = 8'((i * 37 + seed * 11 + 5) & 255); q[i] = p[i]; end
    h = hdr;
    if (hm && wv) h[19:4] = vci;
    if (hm && wp) h[3:1] = pti;
    if (opt == 2'b01) begin
      for (int i = 0; i < 4; i++) exp_b.push_back({(i == 0), h[31 - 8*i -: 8]});
      if (crc) begin
        c = ref_crc(p);
        q[46][1:0] = c[9:8];
        q[47] = c[7:0];
      end
      for (int i = 0; i < 48; i++) begin exp_b.push_back({1'b0, q[i]}); buf_q.push_back(p[i]); end
      err = (mode != 2'b01) || bom || eom || !crc;
    end else err = 1'b1;
    exp_s.push_back({os ? oam_stat_id : vc_stat_id, opt == 2'b01, err});
    @(posedge clk); #1;
    desc_aal_opt = opt; desc_aal_mode = mode; desc_hdr_mod = hm; desc_wr_pti = wp; desc_wr_vci = wv;
    desc_pti = pti; desc_vci = vci; desc_bom = bom; desc_eom = eom; desc_crc10 = crc;
    desc_oam_stat = os; vc_header = hdr; desc_valid = 1'b1;
    forever begin @(negedge clk); if (desc_ready) break; end
    @(posedge clk); #1;
    desc_valid = 1'b0;
    vc_header = ~hdr;
    while (exp_s.size() > 0) @(negedge clk);
    check(exp_b.size() == 0, "R1 all octets delivered", exp_b.size(), 0);
    if (opt == 2'b01) check(buf_q.size() == 0, "R1 48 buffer octets consumed", buf_q.size(), 0);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    check(0, "watchdog", 0, 1);
    done = 1;
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    @(negedge clk);
    tag = "R12";
    check(desc_ready && !cell_valid && !stat_valid && !buf_ready, "reset state", {desc_ready, cell_valid, stat_valid, buf_ready}, 4'b1000);
    // R3 flags set but modify off; R6 CRC; R8 OAM queue
    run_desc(2'b01, 2'b01, 0, 1, 1, 3'b101, 16'd4, 0, 0, 1, 1, 32'hA5C3_F0E7, 1, "R3/R6/R8");
    // R4 F4 segment, VCI only; R8 connection queue
    run_desc(2'b01, 2'b01, 1, 0, 1, 3'b111, 16'd3, 0, 0, 1, 0, 32'h1234_5679, 2, "R4/R8");
    // R5 F5 end-to-end, PTI only
    run_desc(2'b01, 2'b01, 1, 1, 0, 3'b101, 16'hFFFF, 0, 0, 1, 1, 32'hFEDC_BA99, 3, "R5");
    // R7 no CRC, R10 error raised for crc off
    run_desc(2'b01, 2'b01, 0, 0, 0, 3'b000, 16'd0, 0, 0, 0, 0, 32'h0F0F_0F0F, 4, "R7/R10");
    // R10 bom set, bad mode
    run_desc(2'b01, 2'b01, 0, 0, 0, 3'b000, 16'd0, 1, 0, 1, 1, 32'h8000_0001, 5, "R10");
    run_desc(2'b01, 2'b00, 1, 1, 1, 3'b100, 16'd3, 0, 1, 1, 0, 32'h0000_0000, 6, "R10");
    // R9 non-single: presented octet must stay untouched
    buf_q.push_back(8'h5A);
    run_desc(2'b10, 2'b01, 1, 1, 1, 3'b100, 16'd3, 0, 0, 1, 1, 32'h1111_2222, 7, "R9");
    repeat (4) @(negedge clk);
    check(buf_q.size() == 1, "R9 no buffer read", buf_q.size(), 1);
    @(posedge clk); #1;
    buf_q.delete(); buf_valid = 1'b0;
    // R11 backpressure on both sides
    rdy_mode = 1; gap_mode = 1;
    run_desc(2'b01, 2'b01, 1, 1, 1, 3'b100, 16'd4, 0, 0, 1, 1, 32'hCAFE_BABE, 8, "R11/R4/R5");
    run_desc(2'b01, 2'b01, 0, 0, 0, 3'b000, 16'd0, 0, 0, 1, 0, 32'hDEAD_BEEF, 9, "R11/R6");
    run_desc(2'b01, 2'b01, 1, 0, 1, 3'b000, 16'd3, 0, 0, 0, 1, 32'h7777_7777, 10, "R11/R7");
    rdy_mode = 0; gap_mode = 0;
    repeat (5) @(negedge clk);
    done = 1;
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule